// File: doc/BRIEF.md
# Flagged Arithmetic Unit with Operand Muxes

This block is a parameterised WIDTH-bit arithmetic unit built around one adder. A 5-bit function code selects the sources for the adder. The first operand is A or its bitwise inverse. The second operand is B, its inverse, all zeros or all ones. The carry input is the stored carry flag, its inverse, a constant 0 or a constant 1. These choices give add-with-carry, subtract-with-borrow, compare, increment, decrement, negate, pass and bitwise invert, all on the same datapath.

The sum and a write strobe come out combinationally in the cycle the operation is presented. Four status flags (zero, sign, carry/borrow and overflow) are registered. They update on the rising clock edge when `op_valid` is high, and each operation follows its own rule for which flags it may change. The stored carry flag closes the loop, so multi-word additions and subtractions can be chained one word per cycle.

Top module: `arith_flag_unit`

## Requirements
- R1: Code 00000 (add with carry) gives `result` = A + B + carry flag, truncated to WIDTH bits, and raises `result_we` while `op_valid` is high.
- R2: Code 00001 (subtract with borrow) gives `result` = A + NOT B + NOT carry flag, which is A − B − borrow. The carry flag then stores the inverted adder carry-out, so a 1 means a borrow occurred.
- R3: Code 00010 (compare) evaluates A + NOT B + 1 and updates all four flags, with the carry flag holding the inverted carry-out as a borrow. `result_we` stays low.
- R4: Code 00011 (increment) gives A + 1 and code 00100 (decrement) gives A − 1. Both raise `result_we` and update zero and sign, but leave the carry and overflow flags unchanged.
- R5: Code 00101 gives the two's complement NOT A + 1, code 00110 passes A unchanged, and code 00111 gives NOT A. Each raises `result_we`.
- R6: After any valid operation, the zero flag is 1 exactly when all WIDTH bits of the adder output were 0, and the sign flag equals bit WIDTH−1 of that output.
- R7: For operations that update it, the overflow flag equals the adder carry out of bit WIDTH−1 XOR the carry into bit WIDTH−1. This is 1 when both operand MSBs match and the result MSB differs from them.
- R8: For codes 00000, 00101, 00110 and 00111, the carry flag stores the adder carry-out as it is.
- R9: When `op_valid` is low, or the code is 01000 through 11111, `result_we` is low and no flag changes on the next edge.
- R10: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously |
| op_valid | input | 1 | An operation is presented this cycle |
| func | input | 5 | Function code |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Adder output for the current code |
| result_we | output | 1 | `result` is to be written back |
| flag_zero | output | 1 | Registered zero flag |
| flag_sign | output | 1 | Registered sign flag |
| flag_carry | output | 1 | Registered carry/borrow flag |
| flag_ovf | output | 1 | Registered overflow flag |

## Verification
Directed operands come first. Additions that wrap past all ones tell carry-out apart from overflow. Sums that cross 0x7F to 0x80 set overflow without carry. Equal and unequal compares separate the borrow polarity. Increment of 0xFF and decrement of 0x00 show that the carry and overflow flags are held while zero and sign change. Negating 0x00 and 0x80 covers the two corner cases of two's complement. Unused codes and idle cycles placed between flag-setting operations show that nothing is written. A long random sequence over all codes, including invalid ones, then chains the carry flag from one operation into the next, so any wrong carry-in polarity or wrong flag rule builds up into a visible mismatch.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [4:0] {
    FN_ADDC = 5'd0,
    FN_SUBB = 5'd1,
    FN_CMP  = 5'd2,
    FN_INC  = 5'd3,
    FN_DEC  = 5'd4,
    FN_NEG  = 5'd5,
    FN_PASS = 5'd6,
    FN_INV  = 5'd7
  } func_e;

  typedef enum logic {
    OP1_A,
    OP1_NOTA
  } op1_sel_e;

  typedef enum logic [1:0] {
    OP2_B,
    OP2_NOTB,
    OP2_ZERO,
    OP2_ONES
  } op2_sel_e;

  typedef enum logic [1:0] {
    CIN_FLAG,
    CIN_ZERO,
    CIN_ONE,
    CIN_NFLAG
  } cin_sel_e;

  typedef struct packed {
    op1_sel_e op1_sel;
    op2_sel_e op2_sel;
    cin_sel_e cin_sel;
    logic     known;
    logic     wr_res;
    logic     upd_cv;
    logic     store_borrow;
  } ctl_t;

endpackage

// File: rtl/afu_decode.sv
module afu_decode
  import afu_pkg::*;
(
  input  logic [4:0] func,
  output ctl_t       ctl
);

  always_comb begin
    ctl.op1_sel      = OP1_A;
    ctl.op2_sel      = OP2_ZERO;
    ctl.cin_sel      = CIN_ZERO;
    ctl.known        = 1'b0;
    ctl.wr_res       = 1'b0;
    ctl.upd_cv       = 1'b0;
    ctl.store_borrow = 1'b0;
    case (func)
      FN_ADDC: begin
        ctl.op2_sel = OP2_B;
        ctl.cin_sel = CIN_FLAG;
        ctl.known   = 1'b1;
        ctl.wr_res  = 1'b1;
        ctl.upd_cv  = 1'b1;
      end
      FN_SUBB: begin
        ctl.op2_sel      = OP2_NOTB;
        ctl.cin_sel      = CIN_NFLAG;
        ctl.known        = 1'b1;
        ctl.wr_res       = 1'b1;
        ctl.upd_cv       = 1'b1;
        ctl.store_borrow = 1'b1;
      end
      FN_CMP: begin
        ctl.op2_sel      = OP2_NOTB;
        ctl.cin_sel      = CIN_ONE;
        ctl.known        = 1'b1;
        ctl.upd_cv       = 1'b1;
        ctl.store_borrow = 1'b1;
      end
      FN_INC: begin
        ctl.cin_sel = CIN_ONE;
        ctl.known   = 1'b1;
        ctl.wr_res  = 1'b1;
      end
      FN_DEC: begin
        ctl.op2_sel = OP2_ONES;
        ctl.known   = 1'b1;
        ctl.wr_res  = 1'b1;
      end
      FN_NEG: begin
        ctl.op1_sel = OP1_NOTA;
        ctl.cin_sel = CIN_ONE;
        ctl.known   = 1'b1;
        ctl.wr_res  = 1'b1;
        ctl.upd_cv  = 1'b1;
      end
      FN_PASS: begin
        ctl.known  = 1'b1;
        ctl.wr_res = 1'b1;
        ctl.upd_cv = 1'b1;
      end
      FN_INV: begin
        ctl.op1_sel = OP1_NOTA;
        ctl.known   = 1'b1;
        ctl.wr_res  = 1'b1;
        ctl.upd_cv  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/afu_operand_mux.sv
module afu_operand_mux
  import afu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             carry_flag,
  input  op1_sel_e         op1_sel,
  input  op2_sel_e         op2_sel,
  input  cin_sel_e         cin_sel,
  output logic [WIDTH-1:0] op1,
  output logic [WIDTH-1:0] op2,
  output logic             cin
);

  always_comb begin
    case (op1_sel)
      OP1_NOTA: op1 = ~a;
      default:  op1 = a;
    endcase
  end

  always_comb begin
    case (op2_sel)
      OP2_B:    op2 = b;
      OP2_NOTB: op2 = ~b;
      OP2_ONES: op2 = '1;
      default:  op2 = '0;
    endcase
  end

  always_comb begin
    case (cin_sel)
      CIN_FLAG:  cin = carry_flag;
      CIN_ONE:   cin = 1'b1;
      CIN_NFLAG: cin = ~carry_flag;
      default:   cin = 1'b0;
    endcase
  end

endmodule

// File: rtl/afu_adder.sv
module afu_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op1,
  input  logic [WIDTH-1:0] op2,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             c_into_msb
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   cy;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;

  assign cy[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign gen[i]   = op1[i] & op2[i];
    assign prop[i]  = op1[i] ^ op2[i];
    assign sum[i]   = prop[i] ^ cy[i];
    assign cy[i+1]  = gen[i] | (prop[i] & cy[i]);
  end

  assign cout       = cy[WIDTH];
  assign c_into_msb = cy[MSB];

  // R1
  always_comb begin
    adder_sum_chk: assert ({cout, sum} ==
      ({1'b0, op1} + {1'b0, op2} + {{WIDTH{1'b0}}, cin}));
  end

endmodule

// File: rtl/afu_flags.sv
module afu_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_zs,
  input  logic             upd_cv,
  input  logic             store_borrow,
  input  logic [WIDTH-1:0] sum,
  input  logic             cout,
  input  logic             c_into_msb,
  output logic             zero_q,
  output logic             sign_q,
  output logic             carry_q,
  output logic             ovf_q
);

  localparam int MSB = WIDTH - 1;

  logic zero_d, sign_d, carry_d, ovf_d;
  logic en_zs, en_cv;

  always_comb begin
    zero_d  = ~(|sum);
    sign_d  = sum[MSB];
    carry_d = store_borrow ? ~cout : cout;
    ovf_d   = cout ^ c_into_msb;
    en_zs   = upd_zs;
    en_cv   = upd_zs & upd_cv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      sign_q <= 1'b0;
    end else if (en_zs) begin
      zero_q <= zero_d;
      sign_q <= sign_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (en_cv) begin
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  // R10
  always_comb begin
    if (!rst_n) begin
      reset_clear_chk: assert ({zero_q, sign_q, carry_q, ovf_q} == 4'b0000);
    end
  end

endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [4:0]       func,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             flag_zero,
  output logic             flag_sign,
  output logic             flag_carry,
  output logic             flag_ovf
);

  localparam int MSB = WIDTH - 1;

  ctl_t             ctl;
  logic [WIDTH-1:0] op1, op2, sum;
  logic             cin, cout, c_into_msb;

  afu_decode u_decode (
    .func (func),
    .ctl  (ctl)
  );

  afu_operand_mux #(.WIDTH(WIDTH)) u_opmux (
    .a          (a),
    .b          (b),
    .carry_flag (flag_carry),
    .op1_sel    (ctl.op1_sel),
    .op2_sel    (ctl.op2_sel),
    .cin_sel    (ctl.cin_sel),
    .op1        (op1),
    .op2        (op2),
    .cin        (cin)
  );

  afu_adder #(.WIDTH(WIDTH)) u_adder (
    .op1        (op1),
    .op2        (op2),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .c_into_msb (c_into_msb)
  );

  afu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_zs       (op_valid & ctl.known),
    .upd_cv       (ctl.upd_cv),
    .store_borrow (ctl.store_borrow),
    .sum          (sum),
    .cout         (cout),
    .c_into_msb   (c_into_msb),
    .zero_q       (flag_zero),
    .sign_q       (flag_sign),
    .carry_q      (flag_carry),
    .ovf_q        (flag_ovf)
  );

  assign result    = sum;
  assign result_we = op_valid & ctl.wr_res;

  // R3
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && func == FN_CMP) |-> !result_we);

  // R4
  incdec_hold_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (func == FN_INC || func == FN_DEC)) |=> $stable({flag_carry, flag_ovf}));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || func > FN_INV) |=> $stable({flag_zero, flag_sign, flag_carry, flag_ovf}));

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || func > FN_INV) |-> !result_we);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && func <= FN_INV) |=> (flag_zero == ($past(result) == '0)));

  // R7
  signed_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ctl.upd_cv) |=>
      (flag_ovf == $past((op1[MSB] == op2[MSB]) && (sum[MSB] != op1[MSB]))));

endmodule

// File: tb/arith_flag_unit_tb.sv
module arith_flag_unit_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid;
  logic [4:0]   func;
  logic [W-1:0] a, b;
  logic [W-1:0] result;
  logic         result_we;
  logic         flag_zero, flag_sign, flag_carry, flag_ovf;

  int n_checks = 0;
  int n_fails  = 0;

  logic m_z = 1'b0, m_s = 1'b0, m_c = 1'b0, m_v = 1'b0;
  string last_tag = "R10";

  always #10 clk = ~clk;

  arith_flag_unit #(.WIDTH(W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .func       (func),
    .a          (a),
    .b          (b),
    .result     (result),
    .result_we  (result_we),
    .flag_zero  (flag_zero),
    .flag_sign  (flag_sign),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
  );

  function automatic string tag_of(input logic [4:0] fn, input logic vld);
    if (!vld || fn > 5'd7) return "R9";
    case (fn)
      5'd0: return "R1";
      5'd1: return "R2";
      5'd2: return "R3";
      5'd3, 5'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check_flags();
    n_checks++;
    if ({flag_zero, flag_sign, flag_carry, flag_ovf} !== {m_z, m_s, m_c, m_v}) begin
      n_fails++;
      $display("FAIL R6 R7 R8 flags after %s: zscv actual %b%b%b%b expected %b%b%b%b",
               last_tag, flag_zero, flag_sign, flag_carry, flag_ovf, m_z, m_s, m_c, m_v);
    end
  endtask

  task automatic do_op(input logic vld, input logic [4:0] fn,
                       input logic [W-1:0] av, input logic [W-1:0] bv);
    logic [W-1:0] o1, o2, res;
    logic         ci, co, cm, known, we;
    logic [W:0]   full;
    logic [W-1:0] low;
    string        tg;
    @(negedge clk);
    check_flags();
    op_valid = vld; func = fn; a = av; b = bv;
    known = (fn <= 5'd7);
    case (fn)
      5'd0: begin o1 = av;  o2 = bv;  ci = m_c;  end
      5'd1: begin o1 = av;  o2 = ~bv; ci = ~m_c; end
      5'd2: begin o1 = av;  o2 = ~bv; ci = 1'b1; end
      5'd3: begin o1 = av;  o2 = '0;  ci = 1'b1; end
      5'd4: begin o1 = av;  o2 = '1;  ci = 1'b0; end
      5'd5: begin o1 = ~av; o2 = '0;  ci = 1'b1; end
      5'd6: begin o1 = av;  o2 = '0;  ci = 1'b0; end
      default: begin o1 = ~av; o2 = '0; ci = 1'b0; end
    endcase
    full = {1'b0, o1} + {1'b0, o2} + {{W{1'b0}}, ci};
    res  = full[W-1:0];
    co   = full[W];
    low  = {1'b0, o1[W-2:0]} + {1'b0, o2[W-2:0]} + {{(W-1){1'b0}}, ci};
    cm   = low[W-1];
    we   = vld && known && (fn != 5'd2);
    tg   = tag_of(fn, vld);
    #5;
    n_checks++;
    if (result_we !== we || (we && result !== res)) begin
      n_fails++;
      $display("FAIL %s func %0d a %h b %h: we/result actual %b/%h expected %b/%h",
               tg, fn, av, bv, result_we, result, we, res);
    end
    @(posedge clk);
    if (vld && known) begin
      m_z = (res == '0);
      m_s = res[W-1];
      if (fn != 5'd3 && fn != 5'd4) begin
        m_c = (fn == 5'd1 || fn == 5'd2) ? ~co : co;
        m_v = co ^ cm;
      end
    end
    last_tag = tg;
  endtask

  initial begin
    #4_000_000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; func = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // R10: flags clear and no write while in reset
    n_checks++;
    if ({flag_zero, flag_sign, flag_carry, flag_ovf, result_we} !== 5'b0) begin
      n_fails++;
      $display("FAIL R10 reset state actual %b%b%b%b we %b expected 0000 we 0",
               flag_zero, flag_sign, flag_carry, flag_ovf, result_we);
    end
    rst_n = 1'b1;

    do_op(1, 5'd0, 8'h10, 8'h20);  // R1 plain add
    do_op(1, 5'd0, 8'hFF, 8'h01);  // R1 R8 wrap, carry no overflow
    do_op(1, 5'd0, 8'h00, 8'h00);  // R1 carry chained in
    do_op(1, 5'd0, 8'h7F, 8'h01);  // R7 overflow without carry
    do_op(1, 5'd0, 8'h80, 8'h80);  // R7 carry and overflow
    do_op(1, 5'd1, 8'h05, 8'h03);  // R2 borrow from previous carry
    do_op(1, 5'd1, 8'h03, 8'h05);  // R2 borrow out
    do_op(1, 5'd1, 8'h10, 8'h00);  // R2 chained borrow
    do_op(1, 5'd2, 8'h42, 8'h42);  // R3 equal
    do_op(1, 5'd2, 8'h01, 8'h02);  // R3 less, borrow
    do_op(1, 5'd2, 8'h80, 8'h01);  // R3 signed overflow
    do_op(1, 5'd3, 8'hFF, 8'h00);  // R4 increment wraps, carry held
    do_op(1, 5'd4, 8'h00, 8'h00);  // R4 decrement wraps
    do_op(1, 5'd4, 8'h80, 8'h00);  // R4 no overflow update
    do_op(1, 5'd5, 8'h00, 8'h00);  // R5 negate zero
    do_op(1, 5'd5, 8'h80, 8'h00);  // R5 negate most negative
    do_op(1, 5'd6, 8'hA5, 8'h00);  // R5 pass
    do_op(1, 5'd7, 8'hA5, 8'h00);  // R5 invert
    do_op(1, 5'd8, 8'h00, 8'h00);  // R9 unused code
    do_op(1, 5'd31, 8'hFF, 8'h01); // R9 unused code
    do_op(0, 5'd0, 8'hFF, 8'h01);  // R9 idle
    do_op(1, 5'd6, 8'h00, 8'h00);  // R6 zero from pass

    for (int i = 0; i < 400; i++) begin
      logic [4:0] fn;
      fn = 5'($urandom_range(0, 10));
      if (fn == 5'd10) fn = 5'($urandom_range(8, 31));
      do_op(($urandom_range(0, 7) != 0), fn, W'($urandom), W'($urandom));
    end

    @(negedge clk);
    check_flags();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule